// File: doc/BRIEF.md
# Oversampled Multi-Lane SPI Peripheral

This block is an SPI peripheral that lives entirely in the core clock domain. SCK, the active-low chip select and every MOSI lane are treated as plain data inputs. They pass through a synchroniser whose depth is a parameter (0, 1 or 2 stages). SCK edges are found by comparing the current synchronised SCK sample with the one before it. Because SCK is oversampled this way, the core clock must run at more than twice the SCK rate.

Each MOSI lane shifts in one bit per sample edge, most significant bit first. After the last bit of a word, all lanes are presented together as one received vector with a single-cycle valid strobe. Each MISO lane drives one bit of its own reply word, and the reply vector is reloaded when chip select asserts and after every completed word. The MOSI and MISO lane counts are independent. Clock polarity and phase are parameters. An optional output register on MISO gives a glitch-free output at the cost of one extra cycle of response time. Deeper synchronisers also delay the MISO update, which reduces the setup margin left for the master.

Top module: `spiLaneSlave`

## Requirements
- R1: `rxValid` rises exactly SYNC_STAGES+1 clock cycles after the pin-level sample edge that completes a word, and stays high for exactly one cycle.
- R2: The received word of MOSI lane i sits in `rxData[i*WORD_BITS +: WORD_BITS]`. The first bit received is its most significant bit.
- R3: MISO lane j sends `txData[j*WORD_BITS +: WORD_BITS]` most significant bit first. The MSB is present on the pin from chip-select assertion, before the first sample edge.
- R4: Within one chip-select period, the reply vector is reloaded from `txData` when each word completes, so consecutive words carry fresh replies and fresh received data.
- R5: When chip select deasserts in the middle of a word, no `rxValid` pulse is raised for that word, and the next transfer starts again at bit 0.
- R6: A shift edge on the SCK pin changes `misoOut` exactly SYNC_STAGES+1+OUT_REG cycles later. Until then `misoOut` keeps its previous bit.
- R7: While chip select is high (inactive), and after reset, `misoOut` is all zero and `rxValid` is low.
- R8: With CPHA=0, data is sampled on the leading SCK edge and shifted on the trailing edge. With CPHA=1, these roles swap. CPOL gives the idle SCK level, which is also its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | SPI clock pin, sampled as data |
| csNIn | input | 1 | Chip select pin, active low |
| mosiIn | input | MOSI_LANES | Controller-to-peripheral data lanes |
| misoOut | output | MISO_LANES | Peripheral-to-controller data lanes |
| txData | input | MISO_LANES*WORD_BITS | Reply words, one per MISO lane |
| rxData | output | MOSI_LANES*WORD_BITS | Received words, one per MOSI lane |
| rxValid | output | 1 | One-cycle strobe marking a new `rxData` |

## Verification
All latencies are counted from the core clock edge that first captures a changed pin:
- `rxValid` is due SYNC_STAGES+1 edges after the final sample edge and is gone one edge later.
- A MISO bit change is due SYNC_STAGES+1+OUT_REG edges after a shift edge.

The bench drives every pin on the falling core-clock edge and counts falling edges after each drive. It checks `misoOut` one edge before the due point (old bit) and at the due point (new bit), and checks `rxValid` at the edges just before, at and just after its due point. The other data checks are made at the end of each SCK half period, long after every path has settled.

// File: rtl/spiLanePkg.sv
package spiLanePkg;
  // Strobes from control to datapath, valid for one core cycle each
  typedef struct packed {
    logic active;  // chip select asserted (synchronised)
    logic sample;  // sample edge seen while active
    logic shift;   // shift edge seen while active, not at a word boundary
    logic load;    // reload the reply vector
    logic done;    // sample edge carrying the last bit of a word
  } laneStrb_t;
endpackage

// File: rtl/spiLaneSync.sv
module spiLaneSync #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [WIDTH-1:0] stg [DEPTH];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < DEPTH; s++) stg[s] <= RST_VAL;
        end else begin
          stg[0] <= din;
          for (int s = 1; s < DEPTH; s++) stg[s] <= stg[s-1];
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/spiLaneCtrl.sv
module spiLaneCtrl
  import spiLanePkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int CPOL      = 0,
  parameter int CPHA      = 0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sckS,
  input  logic      csNS,
  output laneStrb_t strb
);
  localparam int CNT_W = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic sckPrev, csPrev;
  logic [CNT_W-1:0] bitCnt;
  logic active, rise, fall, leading, trailing, sampleEdge, shiftEdge, lastBit;

  assign active   = ~csNS;
  assign rise     = sckS & ~sckPrev;
  assign fall     = ~sckS & sckPrev;
  assign leading  = (CPOL != 0) ? fall : rise;
  assign trailing = (CPOL != 0) ? rise : fall;
  assign sampleEdge = (CPHA != 0) ? trailing : leading;
  assign shiftEdge  = (CPHA != 0) ? leading  : trailing;
  assign lastBit  = (bitCnt == LAST);

  always_comb begin
    strb.active = active;
    strb.sample = active & sampleEdge;
    strb.done   = active & sampleEdge & lastBit;
    // at a word boundary the reply MSB is already on the lane: hold it
    strb.shift  = active & shiftEdge & (bitCnt != '0);
    strb.load   = (active & ~csPrev) | (active & sampleEdge & lastBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'(CPOL);
      csPrev  <= 1'b0;
      bitCnt  <= '0;
    end else begin
      sckPrev <= sckS;
      csPrev  <= active;
      if (!active)
        bitCnt <= '0;
      else if (sampleEdge)
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/spiLaneData.sv
module spiLaneData
  import spiLanePkg::*;
#(
  parameter int MOSI_LANES = 2,
  parameter int MISO_LANES = 2,
  parameter int WORD_BITS  = 8,
  parameter int OUT_REG    = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  laneStrb_t                       strb,
  input  logic [MOSI_LANES-1:0]           mosiS,
  input  logic [MISO_LANES*WORD_BITS-1:0] txData,
  output logic [MOSI_LANES*WORD_BITS-1:0] rxData,
  output logic                            rxValid,
  output logic [MISO_LANES-1:0]           misoOut
);
  logic [MISO_LANES-1:0] misoRaw;

  generate
    for (genvar i = 0; i < MOSI_LANES; i++) begin : g_rx
      logic [WORD_BITS-1:0] rxShift, rxWord;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rxShift <= '0;
          rxWord  <= '0;
        end else if (strb.sample) begin
          rxShift <= {rxShift[WORD_BITS-2:0], mosiS[i]};
          if (strb.done) rxWord <= {rxShift[WORD_BITS-2:0], mosiS[i]};
        end
      end
      assign rxData[i*WORD_BITS +: WORD_BITS] = rxWord;
    end

    for (genvar j = 0; j < MISO_LANES; j++) begin : g_tx
      logic [WORD_BITS-1:0] txShift;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          txShift <= '0;
        else if (strb.load)
          txShift <= txData[j*WORD_BITS +: WORD_BITS];
        else if (strb.shift)
          txShift <= {txShift[WORD_BITS-2:0], 1'b0};
      end
      assign misoRaw[j] = strb.active & txShift[WORD_BITS-1];
    end

    if (OUT_REG != 0) begin : g_outReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) misoOut <= '0;
        else       misoOut <= misoRaw;
      end
    end else begin : g_outComb
      assign misoOut = misoRaw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxValid <= 1'b0;
    else       rxValid <= strb.done;
  end
endmodule

// File: rtl/spiLaneSlave.sv
module spiLaneSlave
  import spiLanePkg::*;
#(
  parameter int MOSI_LANES  = 2,
  parameter int MISO_LANES  = 2,
  parameter int WORD_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OUT_REG     = 1,
  parameter int CPOL        = 0,
  parameter int CPHA        = 0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            sckIn,
  input  logic                            csNIn,
  input  logic [MOSI_LANES-1:0]           mosiIn,
  output logic [MISO_LANES-1:0]           misoOut,
  input  logic [MISO_LANES*WORD_BITS-1:0] txData,
  output logic [MOSI_LANES*WORD_BITS-1:0] rxData,
  output logic                            rxValid
);
  localparam int PIN_W = MOSI_LANES + 2;
  localparam logic [PIN_W-1:0] PIN_RST = {{MOSI_LANES{1'b0}}, 1'b1, 1'(CPOL)};

  logic [PIN_W-1:0] pinS;
  laneStrb_t strb;

  spiLaneSync #(.DEPTH(SYNC_STAGES), .WIDTH(PIN_W), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({mosiIn, csNIn, sckIn}),
    .dout(pinS)
  );

  spiLaneCtrl #(.WORD_BITS(WORD_BITS), .CPOL(CPOL), .CPHA(CPHA)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sckS(pinS[0]), .csNS(pinS[1]),
    .strb(strb)
  );

  spiLaneData #(.MOSI_LANES(MOSI_LANES), .MISO_LANES(MISO_LANES),
                .WORD_BITS(WORD_BITS), .OUT_REG(OUT_REG)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .mosiS(pinS[PIN_W-1:2]), .txData(txData),
    .rxData(rxData), .rxValid(rxValid), .misoOut(misoOut)
  );
endmodule

// File: rtl/spiLaneSlaveChk.sv
module spiLaneSlaveChk #(
  parameter int MISO_LANES = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  csNIn,
  input logic [MISO_LANES-1:0] misoOut,
  input logic                  rxValid,
  input logic                  smp,
  input logic                  sft,
  input logic                  dn
);
  // R1: the valid strobe lasts one cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R1: the valid strobe follows a completing sample edge by one register
  a_r1_after_done: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(dn));

  // R8: one SCK edge is never both a sample and a shift
  a_r8_edge_roles: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({smp, sft}));

  // R7: chip select held inactive keeps every MISO lane low
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (csNIn && $past(csNIn) && $past(csNIn, 2) && $past(csNIn, 3)) |-> (misoOut == '0));

  // R5: no word is reported while chip select stays inactive
  a_r5_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    (csNIn && $past(csNIn) && $past(csNIn, 2) && $past(csNIn, 3)) |-> !rxValid);
endmodule

bind spiLaneSlave spiLaneSlaveChk #(.MISO_LANES(MISO_LANES)) u_chk (
  .clk(clk), .rstN(rstN), .csNIn(csNIn), .misoOut(misoOut), .rxValid(rxValid),
  .smp(strb.sample), .sft(strb.shift), .dn(strb.done)
);

// File: tb/sim_spiLaneSlave.sv
module sim_spiLaneSlave;
  localparam int HALF = 6;   // core cycles per SCK half period
  localparam int S0 = 2;     // u0 synchroniser depth
  localparam int R0 = 1;     // u0 output register
  localparam int NW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic sck = 1'b0, csN = 1'b1;
  logic [1:0]  mosi = '0;
  logic [15:0] tx0 = '0;
  logic [23:0] tx1 = '0;
  logic [1:0]  miso0;
  logic [2:0]  miso1;
  logic [15:0] rx0;
  logic [7:0]  rx1;
  logic v0, v1, pv0 = 1'b0, pv1 = 1'b0;

  logic [15:0] mo [NW+1];
  logic [15:0] t0 [NW+1];
  logic [23:0] t1 [NW+1];
  int nChk = 0, nErr = 0, rxCnt0 = 0, rxCnt1 = 0;

  always #2 clk = ~clk;

  // mode 0, two lanes each, registered MISO
  spiLaneSlave #(.MOSI_LANES(2), .MISO_LANES(2), .WORD_BITS(8), .SYNC_STAGES(S0),
                 .OUT_REG(R0), .CPOL(0), .CPHA(0)) u0 (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .mosiIn(mosi),
    .misoOut(miso0), .txData(tx0), .rxData(rx0), .rxValid(v0));

  // mode 3 on the inverted clock, one MOSI lane, three MISO lanes, unregistered MISO
  spiLaneSlave #(.MOSI_LANES(1), .MISO_LANES(3), .WORD_BITS(8), .SYNC_STAGES(1),
                 .OUT_REG(0), .CPOL(1), .CPHA(1)) u1 (
    .clk(clk), .rstN(rstN), .sckIn(~sck), .csNIn(csN), .mosiIn(mosi[0]),
    .misoOut(miso1), .txData(tx1), .rxData(rx1), .rxValid(v1));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // received words must arrive in order, each strobe one cycle wide
  always @(negedge clk) begin
    if (rstN) begin
      if (v0) begin
        chk(rx0 == mo[rxCnt0], "R2 u0 rxData", 32'(rx0), 32'(mo[rxCnt0]));
        chk(!pv0, "R1 u0 pulse width", 32'(pv0), 0);
        rxCnt0++;
      end
      if (v1) begin
        chk(rx1 == mo[rxCnt1][7:0], "R8 u1 rxData", 32'(rx1), 32'(mo[rxCnt1][7:0]));
        chk(!pv1, "R1 u1 pulse width", 32'(pv1), 0);
        rxCnt1++;
      end
    end
    pv0 = v0;
    pv1 = v1;
  end

  task automatic xfer(input int base, input int n);
    tx0 = t0[base];
    tx1 = t1[base];
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int idx = base + k;
      tx0 = t0[idx+1];
      tx1 = t1[idx+1];
      for (int b = 0; b < 8; b++) begin
        mosi = {mo[idx][15-b], mo[idx][7-b]};
        repeat (HALF) @(negedge clk);
        chk(miso0 == {t0[idx][15-b], t0[idx][7-b]}, (k == 0) ? "R3 u0 miso" : "R4 u0 miso",
            32'(miso0), 32'({t0[idx][15-b], t0[idx][7-b]}));
        sck = 1'b1;
        for (int c = 1; c <= HALF; c++) begin
          @(negedge clk);
          if (b == 7 && (c == S0 || c == S0 + 2)) chk(v0 == 1'b0, "R1 u0 valid not yet/gone", 32'(v0), 0);
          if (b == 7 && c == S0 + 1) chk(v0 == 1'b1, "R1 u0 valid due", 32'(v0), 1);
        end
        chk(miso1 == {t1[idx][23-b], t1[idx][15-b], t1[idx][7-b]}, "R8 u1 miso",
            32'(miso1), 32'({t1[idx][23-b], t1[idx][15-b], t1[idx][7-b]}));
        sck = 1'b0;
        for (int c = 1; c <= HALF; c++) begin
          @(negedge clk);
          if (b < 7 && c == S0 + R0)
            chk(miso0 == {t0[idx][15-b], t0[idx][7-b]}, "R6 u0 miso held",
                32'(miso0), 32'({t0[idx][15-b], t0[idx][7-b]}));
          if (b < 7 && c == S0 + R0 + 1)
            chk(miso0 == {t0[idx][14-b], t0[idx][6-b]}, "R6 u0 miso due",
                32'(miso0), 32'({t0[idx][14-b], t0[idx][6-b]}));
        end
      end
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    chk(miso0 == '0 && miso1 == '0, "R7 idle miso", 32'({miso1, miso0}), 0);
  endtask

  task automatic abortWord();
    int c0 = rxCnt0, c1 = rxCnt1;
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      mosi = 2'(b + 1);
      repeat (HALF) @(negedge clk) sck = 1'b1;
      repeat (HALF) @(negedge clk) sck = 1'b0;
    end
    repeat (HALF) @(negedge clk) csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    chk(rxCnt0 == c0, "R5 u0 no strobe on abort", 32'(rxCnt0), 32'(c0));
    chk(rxCnt1 == c1, "R5 u1 no strobe on abort", 32'(rxCnt1), 32'(c1));
  endtask

  initial begin
    for (int k = 0; k <= NW; k++) begin
      mo[k] = (k < 8) ? 16'((16'h0101 << k) ^ 16'hff00) : 16'($urandom);
      t0[k] = (k == 0) ? 16'hA55A : (k == 1) ? 16'h00FF : 16'($urandom);
      t1[k] = (k == 0) ? 24'hFF0081 : 24'($urandom);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(v0 == 1'b0 && v1 == 1'b0, "R7 reset valid", 32'({v1, v0}), 0);
    chk(miso0 == '0 && miso1 == '0, "R7 reset miso", 32'({miso1, miso0}), 0);
    chk(rx0 == '0, "R7 reset rxData", 32'(rx0), 0);
    xfer(0, 1);
    xfer(1, 3);
    abortWord();
    xfer(4, 2);   // R5: a correct word here shows the bit count restarted
    xfer(6, 10);
    chk(rxCnt0 == NW, "R4 u0 word count", 32'(rxCnt0), 32'(NW));
    chk(rxCnt1 == NW, "R4 u1 word count", 32'(rxCnt1), 32'(NW));
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    nChk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule